// File: doc/BRIEF.md
# Embedded Operation Status Poller

This block is a behavioural model of a small flash byte array that carries out embedded byte-program, sector-erase and chip-erase operations. Each operation is started by a single-cycle strobe and lasts for a fixed number of clock cycles set by a parameter. A `busy` output stays high for the whole of that time. The result is written to the array in the last cycle of the operation.

A host reads the block through a registered read port. While no operation is running, a read returns the stored byte. While an operation is running, a read returns a status byte, whatever address is given. The status byte carries a data-polling bit and a toggle bit, so the host can track progress by reading twice in a row. Once the operation finishes, the block goes back to array reads by itself.

The array depth is a parameter. The sector boundaries scale with the depth and are decoded from the top five address bits.

Top module: `flash_status_core`

## Requirements
- R1: After reset `busy` is 0, `rd_data` is 00h and every array byte reads FFh.
- R2: A status read returns the data-polling bit on bit 7. During a program this bit is the inverse of bit 7 of the byte being written. During a sector or chip erase it is 0.
- R3: The status toggle bit is on bit 6. It is cleared when an operation starts. The first status read of an operation returns 0 on this bit, and each later status read in the same operation returns the inverse of the previous one.
- R4: Bits 5..0 of a status byte are 0. `rd_data` shows the result of a read one cycle after `rd_en` is sampled high. `rd_data` keeps its value while `rd_en` is low.
- R5: Once `busy` has fallen, the next read returns array contents, including the result of the operation that just completed.
- R6: A program stores the bitwise AND of the old byte and the new data, so no bit can go from 0 to 1.
- R7: A program or erase strobe sampled while `busy` is high has no effect: the array is unchanged and the operation in progress is not altered.
- R8: A sector erase sets to FFh every byte in the sector that holds `op_addr`, and only those bytes. Sectors are decoded from the top five address bits t[4:0]:
  - t[4]=0 selects the main sector.
  - t[4]=1 with t[3:2]≠11 selects the large sector.
  - t=11100 selects parameter sector 2.
  - t=11101 selects parameter sector 1.
  - t=1111x selects the boot sector.
- R9: A chip erase sets every byte of the array to FFh.
- R10: `busy` rises in the cycle after an accepted strobe. It stays high for PROG_CYC cycles for a program and ERASE_CYC cycles for either erase.
- R11: When more than one strobe is high in the same cycle, only one is accepted. A program takes priority over a sector erase, which takes priority over a chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_stb | input | 1 | Start a byte program at `op_addr` with `op_data` |
| sect_erase_stb | input | 1 | Start an erase of the sector holding `op_addr` |
| chip_erase_stb | input | 1 | Start an erase of the whole array |
| op_addr | input | ADDR_W | Target address of the operation |
| op_data | input | 8 | Byte to program |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte when idle, status byte when busy; registered |
| busy | output | 1 | An embedded operation is in progress |

## Verification
The bench polls every operation with back-to-back reads. It expects the toggle bit to start at 0 for each new operation and to flip on every read. A design that let the toggle carry over between operations, or advance without a read, would fail on the second operation.

The bench programs a cleared bit back to 1 and expects the stored byte to stay cleared. A design that simply overwrote the byte would fail this check. It also erases bytes on both sides of every sector boundary, which catches a decoder with an off-by-one boundary.

Strobes are issued while an operation is running, and two strobes are issued in the same cycle. A design that restarted an operation, queued a strobe or broke priority the wrong way would leave a byte altered.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_CHIP = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        SEC_MAIN = 3'd0,
        SEC_BIG  = 3'd1,
        SEC_PAR2 = 3'd2,
        SEC_PAR1 = 3'd3,
        SEC_BOOT = 3'd4
    } sector_e;

    typedef struct packed {
        logic       poll;
        logic       tog;
        logic [5:0] rsvd;
    } status_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
    localparam int         SEC_BITS    = 5;

    // Map the top five address bits to a sector.
    function automatic sector_e sector_of(input logic [SEC_BITS-1:0] t);
        if (!t[4])                 return SEC_MAIN;
        else if (t[3:2] != 2'b11)  return SEC_BIG;
        else if (t[1])             return SEC_BOOT;
        else if (t[0])             return SEC_PAR1;
        else                       return SEC_PAR2;
    endfunction

endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_stb,
    input  logic              sect_stb,
    input  logic              chip_stb,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    output logic              busy,
    output logic              done,
    output logic              start,
    output op_kind_e          kind,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [7:0]        lat_data
);
    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;
    op_kind_e         req_kind;

    always_comb begin
        if (prog_stb)      req_kind = OP_PROG;
        else if (sect_stb) req_kind = OP_SECT;
        else if (chip_stb) req_kind = OP_CHIP;
        else               req_kind = OP_IDLE;
    end

    assign start = !busy && (req_kind != OP_IDLE);
    assign done  = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            kind     <= OP_IDLE;
            lat_addr <= '0;
            lat_data <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            kind     <= req_kind;
            lat_addr <= op_addr;
            lat_data <= op_data;
            cnt      <= (req_kind == OP_PROG) ? CNT_W'(PROG_CYC - 1)
                                              : CNT_W'(ERASE_CYC - 1);
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
                kind <= OP_IDLE;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_poll_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     rd_en,
    input  logic     busy,
    input  op_kind_e kind,
    input  logic     poll_src,
    output status_t  status
);
    logic tog;

    always_ff @(posedge clk) begin
        if (rst || start) tog <= 1'b0;
        else if (rd_en && busy) tog <= ~tog;
    end

    always_comb begin
        status.poll = (kind == OP_PROG) ? ~poll_src : 1'b0;
        status.tog  = tog;
        status.rsvd = '0;
    end
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  op_kind_e          kind,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic [7:0]        lat_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0]       mem [DEPTH];
    logic [DEPTH-1:0] hit;
    sector_e          tgt_sec;

    assign tgt_sec = sector_of(lat_addr[ADDR_W-1 -: SEC_BITS]);

    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        localparam logic [ADDR_W-1:0] GA = ADDR_W'(g);
        assign hit[g] = (kind == OP_CHIP)
                     || ((kind == OP_SECT) && (sector_of(GA[ADDR_W-1 -: SEC_BITS]) == tgt_sec))
                     || ((kind == OP_PROG) && (lat_addr == GA));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
        end else if (done) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hit[i]) mem[i] <= (kind == OP_PROG) ? (mem[i] & lat_data) : ERASED_BYTE;
            end
        end
    end

    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/flash_status_core.sv
module flash_status_core
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_stb,
    input  logic              sect_erase_stb,
    input  logic              chip_erase_stb,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    logic              busy_i, done, start;
    op_kind_e          kind;
    logic [ADDR_W-1:0] lat_addr;
    logic [7:0]        lat_data, arr_word;
    status_t           status;

    flash_op_timer #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
        .clk(clk), .rst(rst),
        .prog_stb(prog_stb), .sect_stb(sect_erase_stb), .chip_stb(chip_erase_stb),
        .op_addr(op_addr), .op_data(op_data),
        .busy(busy_i), .done(done), .start(start), .kind(kind),
        .lat_addr(lat_addr), .lat_data(lat_data)
    );

    flash_status_gen u_stat (
        .clk(clk), .rst(rst), .start(start), .rd_en(rd_en), .busy(busy_i),
        .kind(kind), .poll_src(lat_data[7]), .status(status)
    );

    flash_byte_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .rst(rst), .done(done), .kind(kind),
        .lat_addr(lat_addr), .lat_data(lat_data),
        .rd_addr(rd_addr), .rd_word(arr_word)
    );

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= busy_i ? status : arr_word;
    end

    assign busy = busy_i;
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input op_kind_e          kind,
    input logic [ADDR_W-1:0] lat_addr,
    input logic              rd_en,
    input logic [7:0]        rd_data,
    input logic              prog_stb,
    input logic              sect_stb,
    input logic              chip_stb
);
    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(prog_stb || sect_stb || chip_stb));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R5
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R3
    toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_en && $past(busy && rd_en)) |=> (rd_data[6] != $past(rd_data[6])));

    // R2
    erase_poll_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy && (kind == OP_SECT || kind == OP_CHIP)) |=> !rd_data[7]);

    // R4
    status_low_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) |=> (rd_data[5:0] == 6'd0));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(lat_addr));
endmodule

bind flash_status_core flash_status_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy_i), .done(done), .kind(kind),
    .lat_addr(lat_addr), .rd_en(rd_en), .rd_data(rd_data),
    .prog_stb(prog_stb), .sect_stb(sect_erase_stb), .chip_stb(chip_erase_stb)
);

// File: tb/tb_flash_status_core.sv
`timescale 1ns/1ps
module tb_flash_status_core;
    localparam int AW = 8;
    localparam int PC = 6;
    localparam int EC = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prog_stb = 1'b0, sect_erase_stb = 1'b0, chip_erase_stb = 1'b0;
    logic [AW-1:0] op_addr = '0, rd_addr = '0;
    logic [7:0]    op_data = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic          busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit         pend = 0;

    always #10 clk = ~clk;

    flash_status_core #(.ADDR_W(AW), .PROG_CYC(PC), .ERASE_CYC(EC)) dut (
        .clk(clk), .rst(rst), .prog_stb(prog_stb), .sect_erase_stb(sect_erase_stb),
        .chip_erase_stb(chip_erase_stb), .op_addr(op_addr), .op_data(op_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // monitor: a read sampled at a rising edge is compared at the next falling edge
    always @(posedge clk) pend = rd_en && !rst;
    always @(negedge clk) begin
        if (pend) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rd_data === e, t, rd_data, e);
        end
    end

    task automatic do_read(input logic [AW-1:0] a, input logic [7:0] e, input string t);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic strobe(input int k, input logic [AW-1:0] a, input logic [7:0] d);
        prog_stb = (k & 1) != 0; sect_erase_stb = (k & 2) != 0; chip_erase_stb = (k & 4) != 0;
        op_addr = a; op_data = d;
        @(negedge clk);
        prog_stb = 0; sect_erase_stb = 0; chip_erase_stb = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
        strobe(1, a, d);
        wait_idle();
    endtask

    function automatic logic [7:0] prog_stat(input logic [7:0] d, input bit t);
        return {~d[7], t, 6'b0};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        n_bad++;
        finish_run();
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0, "R1 busy after reset", busy, 0);
        check(rd_data === 8'h00, "R1 rd_data after reset", rd_data, 0);
        do_read(8'h00, 8'hFF, "R1 erased byte 00");
        do_read(8'hFF, 8'hFF, "R1 erased byte FF");

        // program with status polling
        strobe(1, 8'h05, 8'h5A);
        do_read(8'h33, prog_stat(8'h5A, 0), "R2/R3 first program status");
        do_read(8'h05, prog_stat(8'h5A, 1), "R3 second status toggles");
        do_read(8'h90, prog_stat(8'h5A, 0), "R3 third status toggles back");
        wait_idle();
        do_read(8'h05, 8'h5A, "R5 data after program");
        @(negedge clk); @(negedge clk);
        check(rd_data === 8'h5A, "R4 rd_data held", rd_data, 8'h5A);

        // program duration
        strobe(1, 8'h06, 8'h3C);
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
        check(cnt == PC, "R10 program busy length", cnt, PC);
        do_read(8'h06, 8'h3C, "R5 second programmed byte");

        // program AND, toggle restart, ignored strobes
        strobe(1, 8'h05, 8'hA5);
        do_read(8'h05, prog_stat(8'hA5, 0), "R2/R3 status new op restarts toggle");
        do_read(8'h05, prog_stat(8'hA5, 1), "R3 status second read");
        strobe(1, 8'h07, 8'h00);
        strobe(4, 8'h00, 8'h00);
        wait_idle();
        do_read(8'h05, 8'h00, "R6 program ANDs old data");
        do_read(8'h07, 8'hFF, "R7 program strobe while busy ignored");
        do_read(8'h06, 8'h3C, "R7 chip erase strobe while busy ignored");

        // simultaneous strobes
        strobe(5, 8'h08, 8'h11);
        wait_idle();
        do_read(8'h08, 8'h11, "R11 program wins over chip erase");
        do_read(8'h06, 8'h3C, "R11 chip erase not run");

        // parameter sector 1 erase
        program_byte(8'hE7, 8'h01);
        program_byte(8'hE8, 8'h02);
        program_byte(8'hEF, 8'h03);
        program_byte(8'hF0, 8'h04);
        strobe(2, 8'hEA, 8'h00);
        do_read(8'h00, 8'h00, "R2 erase status poll bit zero");
        do_read(8'h00, 8'h40, "R3 erase status toggles");
        cnt = 2;
        while (busy) begin cnt++; @(negedge clk); end
        check(cnt == EC, "R10 erase busy length", cnt, EC);
        do_read(8'hE7, 8'h01, "R8 param2 byte kept");
        do_read(8'hE8, 8'hFF, "R8 param1 low erased");
        do_read(8'hEF, 8'hFF, "R8 param1 high erased");
        do_read(8'hF0, 8'h04, "R8 boot byte kept");

        // main sector erase
        strobe(2, 8'h10, 8'h00);
        wait_idle();
        do_read(8'h05, 8'hFF, "R8 main erased 05");
        do_read(8'h08, 8'hFF, "R8 main erased 08");
        do_read(8'hE7, 8'h01, "R8 param2 kept after main erase");

        // large sector erase
        program_byte(8'h7F, 8'h77);
        program_byte(8'h80, 8'h55);
        program_byte(8'hDF, 8'h66);
        program_byte(8'hE0, 8'h12);
        strobe(2, 8'hC0, 8'h00);
        wait_idle();
        do_read(8'h80, 8'hFF, "R8 large low erased");
        do_read(8'hDF, 8'hFF, "R8 large high erased");
        do_read(8'h7F, 8'h77, "R8 main kept after large erase");
        do_read(8'hE0, 8'h12, "R8 param2 kept after large erase");

        // boot sector erase
        strobe(2, 8'hFF, 8'h00);
        wait_idle();
        do_read(8'hF0, 8'hFF, "R8 boot erased");
        do_read(8'hE7, 8'h01, "R8 param2 kept after boot erase");

        // chip erase
        program_byte(8'h00, 8'h00);
        strobe(4, 8'h00, 8'h00);
        do_read(8'h00, 8'h00, "R2 chip erase status");
        do_read(8'h00, 8'h40, "R3 chip erase toggle");
        wait_idle();
        for (int i = 0; i < 256; i++) do_read(AW'(i), 8'hFF, "R9 chip erase all FF");
        @(negedge clk); @(negedge clk);
        finish_run();
    end
endmodule